// File: doc/BRIEF.md
# PCI I/O Window Decoder

This block holds the low and high decode fields that place the CPU's window onto PCI I/O space, and turns them into a registered base address and length. The window is measured in 2 MiB units. The low field sets where the window starts, and the high field sets its last unit. A write to either field starts one evaluation pass. If the pair is consistent, the pass installs the new window. If it is not consistent, the window in force stays as it is.

Each time an active window is replaced, the block announces the window it retires for one cycle, so a neighbouring fabric can tear that window down. A combinational hit output tells whether the current CPU address falls inside the installed window.

A two-state machine sequences the work:
- `ST_EVAL` is the evaluation pass. Reset enters it, so the reset field values are decoded once.
- `ST_IDLE` holds the window.
- Transition *strobe*: any field write moves the machine to `ST_EVAL`. It enters from either state.
- Transition *settle*: `ST_EVAL` with no field write goes back to `ST_IDLE`.

Top module: `pci_io_window`

## Requirements
- R1: After reset the low field is 0x80 and the high field is 0x0F. The reset values are evaluated once, which gives base 0x1000_0000 and length 0x0200_0000. No retire pulse is raised for this first pass.
- R2: A low-field write keeps bits [14:0] of `lo_wdata`. A high-field write keeps bits [6:0] of `hi_wdata`. All other bits are dropped.
- R3: A pair is consistent when bits [6:0] of the low field are less than or equal to the high field. An evaluation of an inconsistent pair leaves base and length unchanged.
- R4: On a consistent evaluation, the base becomes the low field shifted left by 21 bits, truncated to 32 bits.
- R5: On a consistent evaluation, the length becomes (high + 1 − low[6:0]) shifted left by 21 bits.
- R6: When a consistent evaluation replaces a window of nonzero length, `unmap_valid` is high for the following cycle. During that cycle `unmap_base` and `unmap_len` carry the replaced window's base and length.
- R7: `hit` is high exactly when the length is nonzero and base ≤ `cpu_addr` < base + length. The upper bound is computed without 32-bit wrap.
- R8: Base and length change only on the second rising edge after a write strobe. They hold their value at every other edge.
- R9: Both fields may be written in the same cycle. The evaluation then uses both new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_wr | input | 1 | Write strobe for the low field |
| lo_wdata | input | 32 | Low-field write data |
| hi_wr | input | 1 | Write strobe for the high field |
| hi_wdata | input | 32 | High-field write data |
| cpu_addr | input | 32 | CPU address to classify |
| hit | output | 1 | Address falls inside the window |
| win_base | output | 32 | Installed window base |
| win_len | output | 32 | Installed window length (0 = none) |
| unmap_valid | output | 1 | One-cycle retire notice |
| unmap_base | output | 32 | Base of the retired window |
| unmap_len | output | 32 | Length of the retired window |

## Verification
The assertions assume that strobes and data are stable across each rising edge. They also assume that reset is held for at least one edge before any check matters, because the properties rely on the state machine having left its reset pass. The stimulus drives every input one time unit after a rising edge and holds reset for several cycles, so both assumptions hold. Strobe bursts on consecutive cycles are allowed: the machine simply stays in `ST_EVAL`, and the bench model follows it edge by edge.

// File: rtl/pci_io_window_pkg.sv
package pci_io_window_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } win_state_e;
endpackage

// File: rtl/win_field_regs.sv
module win_field_regs #(
    parameter int DATA_W = 32,
    parameter int LO_W   = 15,
    parameter int HI_W   = 7,
    parameter logic [LO_W-1:0] LO_RST = '0,
    parameter logic [HI_W-1:0] HI_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic [DATA_W-1:0] lo_wdata,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] hi_wdata,
    output logic [LO_W-1:0]   lo_q,
    output logic [HI_W-1:0]   hi_q,
    output logic              strobe
);
    // R2: only the implemented bits of each field are kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= LO_RST;
            hi_q <= HI_RST;
        end else begin
            if (lo_wr) lo_q <= lo_wdata[LO_W-1:0];
            if (hi_wr) hi_q <= hi_wdata[HI_W-1:0];
        end
    end

    assign strobe = lo_wr | hi_wr;
endmodule

// File: rtl/win_eval_fsm.sv
module win_eval_fsm
    import pci_io_window_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LO_W   = 15,
    parameter int HI_W   = 7,
    parameter int SHIFT  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [LO_W-1:0]   lo_q,
    input  logic [HI_W-1:0]   hi_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] len_q,
    output logic              unmap_v,
    output logic [ADDR_W-1:0] unmap_base,
    output logic [ADDR_W-1:0] unmap_len
);
    localparam int UNIT_W = HI_W + 1;

    win_state_e state_q, state_d;

    logic [HI_W-1:0]   lo_fld;
    logic              pair_ok;
    logic [UNIT_W-1:0] units;
    logic [ADDR_W-1:0] new_base, new_len;

    assign lo_fld   = lo_q[HI_W-1:0];
    assign pair_ok  = (lo_fld <= hi_q);
    assign units    = ({1'b0, hi_q} + UNIT_W'(1)) - {1'b0, lo_fld};
    assign new_base = ADDR_W'(lo_q) << SHIFT;
    assign new_len  = ADDR_W'(units) << SHIFT;

    // strobe enters ST_EVAL, settle returns to ST_IDLE
    always_comb begin
        state_d = strobe ? ST_EVAL : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EVAL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            len_q      <= '0;
            unmap_v    <= 1'b0;
            unmap_base <= '0;
            unmap_len  <= '0;
        end else begin
            unmap_v <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_EVAL: begin
                    if (pair_ok) begin
                        unmap_v    <= (len_q != '0);
                        unmap_base <= base_q;
                        unmap_len  <= len_q;
                        base_q     <= new_base;
                        len_q      <= new_len;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(base_q) && $stable(len_q)));

    p_keep_bad_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && !pair_ok) |=> ($stable(base_q) && $stable(len_q)));

    p_retire_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unmap_v |-> (unmap_len != '0));

    p_len_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (len_q != '0));
endmodule

// File: rtl/win_hit_cmp.sv
module win_hit_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len,
    output logic              hit
);
    logic [ADDR_W:0] top_x;

    // R7: one extra bit so a window ending at the top of the space does not wrap
    assign top_x = {1'b0, base} + {1'b0, len};
    assign hit   = (len != '0) && (addr >= base) && ({1'b0, addr} < top_x);

    always_comb begin
        if (hit) begin
            p_hit_floor_r7: assert (addr >= base && len != '0);
        end
    end
endmodule

// File: rtl/pci_io_window.sv
module pci_io_window #(
    parameter int ADDR_W = 32,
    parameter int LO_W   = 15,
    parameter int HI_W   = 7,
    parameter int SHIFT  = 21,
    parameter logic [LO_W-1:0] LO_RST = LO_W'(8'h80),
    parameter logic [HI_W-1:0] HI_RST = HI_W'(8'h0F)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic [ADDR_W-1:0] lo_wdata,
    input  logic              hi_wr,
    input  logic [ADDR_W-1:0] hi_wdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              hit,
    output logic [ADDR_W-1:0] win_base,
    output logic [ADDR_W-1:0] win_len,
    output logic              unmap_valid,
    output logic [ADDR_W-1:0] unmap_base,
    output logic [ADDR_W-1:0] unmap_len
);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            strobe;

    win_field_regs #(
        .DATA_W(ADDR_W), .LO_W(LO_W), .HI_W(HI_W),
        .LO_RST(LO_RST), .HI_RST(HI_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata),
        .lo_q(lo_q), .hi_q(hi_q), .strobe(strobe)
    );

    win_eval_fsm #(
        .ADDR_W(ADDR_W), .LO_W(LO_W), .HI_W(HI_W), .SHIFT(SHIFT)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .lo_q(lo_q), .hi_q(hi_q),
        .base_q(win_base), .len_q(win_len),
        .unmap_v(unmap_valid), .unmap_base(unmap_base), .unmap_len(unmap_len)
    );

    win_hit_cmp #(.ADDR_W(ADDR_W)) hit_i (
        .addr(cpu_addr), .base(win_base), .len(win_len), .hit(hit)
    );
endmodule

// File: tb/pci_io_window_tb_top.sv
module pci_io_window_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lo_wr = 1'b0, hi_wr = 1'b0;
    logic [31:0] lo_wdata = '0, hi_wdata = '0, cpu_addr = '0;
    logic        hit, unmap_valid;
    logic [31:0] win_base, win_len, unmap_base, unmap_len;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_io_window dut_i (
        .clk(clk), .rst_n(rst_n),
        .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata),
        .cpu_addr(cpu_addr), .hit(hit),
        .win_base(win_base), .win_len(win_len),
        .unmap_valid(unmap_valid), .unmap_base(unmap_base), .unmap_len(unmap_len)
    );

    // behavioural reference model
    longint m_lo, m_hi, m_base, m_len, m_ub, m_ul;
    bit     m_pend, m_unv;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 'h80; m_hi = 'h0F; m_pend = 1;
            m_base = 0; m_len = 0; m_ub = 0; m_ul = 0; m_unv = 0;
        end else begin
            m_unv = 0;
            if (m_pend && ((m_lo % 128) <= m_hi)) begin
                m_unv  = (m_len != 0);
                m_ub   = m_base;
                m_ul   = m_len;
                m_base = (m_lo * 2097152) % 64'h1_0000_0000;
                m_len  = ((m_hi + 1) - (m_lo % 128)) * 2097152;
            end
            m_pend = lo_wr || hi_wr;
            if (lo_wr) m_lo = lo_wdata % 32768;
            if (hi_wr) m_hi = hi_wdata % 128;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            longint a;
            bit     eh;
            a  = cpu_addr;
            eh = (m_len != 0) && (a >= m_base) && (a < m_base + m_len);
            chk("R4 base", win_base, m_base);
            chk("R5 len", win_len, m_len);
            chk("R6 unmap_valid", unmap_valid, m_unv);
            if (m_unv) begin
                chk("R6 unmap_base", unmap_base, m_ub);
                chk("R6 unmap_len", unmap_len, m_ul);
            end
            chk("R7 hit", hit, eh);
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // strobe in one cycle; returns just after the evaluating edge
    task automatic do_wr(bit le, bit he, logic [31:0] ld, logic [31:0] hd);
        @(posedge clk); #1;
        lo_wr = le; hi_wr = he; lo_wdata = ld; hi_wdata = hd;
        @(posedge clk); #1;
        lo_wr = 0; hi_wr = 0;
        @(posedge clk); #1;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        logic [31:0] lf;
        logic [31:0] old_b;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        idle(3);
        // R1: reset pair decoded once, no retire
        chk("R1 base", win_base, 32'h1000_0000);
        chk("R1 len", win_len, 32'h0200_0000);
        chk("R1 unmap_valid", unmap_valid, 0);

        do_wr(0, 1, 0, 32'h1F);
        chk("R6 retire pulse", unmap_valid, 1);
        chk("R6 retire len", unmap_len, 32'h0200_0000);
        chk("R5 len widened", win_len, 32'h0400_0000);
        idle(1);
        chk("R6 one cycle", unmap_valid, 0);

        do_wr(1, 0, 32'h85, 0);
        chk("R4 base", win_base, 32'h10A0_0000);
        chk("R5 len", win_len, 32'h0360_0000);

        // R8: no change one edge after the strobe
        @(posedge clk); #1;
        old_b = win_base;
        lo_wr = 1; lo_wdata = 32'h03;
        @(posedge clk); #1;
        lo_wr = 0;
        chk("R8 held after first edge", win_base, old_b);
        @(posedge clk); #1;
        chk("R8 updated after second edge", win_base, 32'h0060_0000);

        // R3: inconsistent pair keeps window
        do_wr(1, 0, 32'h40, 0);
        chk("R3 base kept", win_base, 32'h0060_0000);
        chk("R3 len kept", win_len, 32'h03A0_0000);

        // R2: high field keeps only 7 bits (0x05), pair stays inconsistent
        do_wr(0, 1, 0, 32'hFFFF_FF85);
        chk("R2 hi masked", win_len, 32'h03A0_0000);
        // R2/R3: only low[6:0] compared: 0x83 -> 3 <= 5
        do_wr(1, 0, 32'hFFFF_8083, 0);
        chk("R2 base", win_base, 32'h1060_0000);
        chk("R3 low field compare", win_len, 32'h0060_0000);

        // R9: both fields at once, window at top of space
        do_wr(1, 1, 32'h7FF, 32'h7F);
        chk("R9 base", win_base, 32'hFFE0_0000);
        chk("R9 len", win_len, 32'h0020_0000);
        chk("R9 retired base", unmap_base, 32'h1060_0000);
        cpu_addr = 32'hFFFF_FFFF; #1;
        chk("R7 top hit", hit, 1);
        cpu_addr = 32'hFFDF_FFFF; #1;
        chk("R7 below miss", hit, 0);
        idle(1);

        // boundary sweep and pseudo-random fields, checked per cycle by the model
        lf = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            do_wr(lf[0], lf[1] | ~lf[0], {21'd0, lf[12:2]} & 32'h0000_0FFF,
                  {25'd0, lf[19:13]} | 32'h0000_0040);
            cpu_addr = win_base - 1;           idle(1);
            cpu_addr = win_base;               idle(1);
            cpu_addr = win_base + win_len - 1; idle(1);
            cpu_addr = win_base + win_len;     idle(1);
        end
        // back-to-back strobes
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            lo_wr = 1; lo_wdata = 32'(i * 3);
            hi_wr = i[0]; hi_wdata = 32'(20 + i);
        end
        @(posedge clk); #1;
        lo_wr = 0; hi_wr = 0;
        idle(4);
        finish_run();
    end
endmodule